// File: doc/BRIEF.md
# Serial Link Test Pattern Generator

This block feeds a 16-bit-per-word serial transmitter. Each time the transmitter takes a word (`word_tick`), the block registers the next outgoing word. It also registers two per-byte flags that mark bytes as control characters. Normally the word is the live ADC sample. With test mode enabled, the word instead comes from one of three internal sources:

- an incrementing ramp;
- a 16-bit maximal-length pseudo-random sequence;
- a fixed marker word.

Software can request that exactly one outgoing data word be corrupted, so that the receiver's error detection can be exercised. An alignment mode sends comma characters in place of data, so the far end can lock its word boundary. An inhibit control silences the link, and a link-reset control restarts the generators.

A parameter selects the spare-link variant. In that variant the two lower source selections produce fixed words instead of the ramp and the pseudo-random sequence.

Top module: `lnk_testgen`

## Requirements
- R1: After `rst`, `tx_word` is 0x0000, `tx_is_k` is 2'b00 and `tx_valid` is 0.
- R2: With `test_en`=0, a `word_tick` cycle sends `live_data` on `tx_word` from the next clock edge, with `tx_valid`=1 and `tx_is_k`=00. Without `word_tick`, inhibit or link reset, all outputs hold.
- R3: With `test_sel`=2'b00 (ramp), the first data word after reset or link reset is 0x0000. Each later data word is one larger, and the value wraps from 0xFFFF to 0x0000.
- R4: With `test_sel`=2'b01 (pseudo-random), the first data word after reset is the seed 0xACE1. Each next value is the previous one shifted left by one. The new bit 0 is the XOR of bits 15, 13, 12 and 10 of the previous value.
- R5: With `test_sel`=2'b10 or 2'b11, every data word is 0xDEAD.
- R6: When `SPARE_LINK`=1, `test_sel`=2'b00 gives 0xF00D, 2'b01 gives 0xC01D, and 2'b10 or 2'b11 give 0xDEAD.
- R7: A clock edge that sees `err_req`=1 while the request is armed does two things. It flips bit 0 of the next data word only, and it disarms the request. The request arms again only at an edge that sees `err_req`=0. A pending flip survives alignment and inhibit cycles.
- R8: A `word_tick` with `ctl_align`=1 sends 0xBCBC with `tx_is_k`=2'b11 and consumes no ramp, pseudo-random or pending-flip state. Once `ctl_align` is cleared, data words return with `tx_is_k`=00.
- R9: `ctl_inhibit`=1 forces `tx_word`=0x0000, `tx_is_k`=00 and `tx_valid`=0 at the next edge, whether or not `word_tick` is set, and advances no generator.
- R10: `ctl_link_rst`=1 returns the outputs to the R1 state and the ramp to 0x0000, the pseudo-random register to its seed, and clears any pending flip.
- R11: Ramp and pseudo-random registers both advance on every data word sent, whatever `test_en` and `test_sel` select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_tick | input | 1 | Transmitter takes a word this cycle |
| live_data | input | 16 | Live ADC sample |
| test_en | input | 1 | 1 selects the test source instead of live data |
| test_sel | input | 2 | Test source selection |
| err_req | input | 1 | Single-word corruption request |
| ctl_align | input | 1 | Send comma characters instead of data |
| ctl_inhibit | input | 1 | Stop the link sending |
| ctl_link_rst | input | 1 | Restart the generator logic |
| tx_word | output | 16 | Outgoing word |
| tx_is_k | output | 2 | Per-byte control-character flags |
| tx_valid | output | 1 | Word being sent is meaningful |

## Verification
The hardest situation to reach from the ports is the ramp wrap from 0xFFFF to 0x0000. It needs 65,536 data words after a link reset. The stimulus holds `word_tick` high for 65,535 consecutive cycles, then steps single words to observe 0xFFFF and then 0x0000.

A second hard case is a pending flip that must outlive an alignment word. The stimulus raises `err_req` while no word is taken, sends an alignment word, and only then sends data. This shows that exactly that data word carries the flipped bit.

// File: rtl/lnk_tg_pkg.sv
package lnk_tg_pkg;

    localparam int TG_W = 16;
    localparam int TG_B = TG_W / 8;

    typedef enum logic [1:0] {
        SRC_RAMP  = 2'b00,
        SRC_PRNG  = 2'b01,
        SRC_MARK  = 2'b10,
        SRC_MARK2 = 2'b11
    } src_sel_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_MUTE,
        ACT_ALIGN,
        ACT_DATA
    } tg_act_e;

    typedef struct packed {
        logic [TG_W-1:0] data;
        logic [TG_B-1:0] is_k;
        logic            valid;
    } tx_beat_t;

    localparam logic [TG_W-1:0] MARK_COMMON = 16'hDEAD;
    localparam logic [TG_W-1:0] MARK_SPARE0 = 16'hF00D;
    localparam logic [TG_W-1:0] MARK_SPARE1 = 16'hC01D;

    // x^16 + x^14 + x^13 + x^11 + 1, Fibonacci form
    function automatic logic [TG_W-1:0] lfsr_step(input logic [TG_W-1:0] s);
        return {s[TG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/lnk_tg_source.sv
module lnk_tg_source
    import lnk_tg_pkg::*;
#(
    parameter bit              SPARE_LINK = 1'b0,
    parameter logic [TG_W-1:0] LFSR_SEED  = 16'hACE1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            adv,
    input  src_sel_e        sel,
    output logic [TG_W-1:0] src_word
);

    logic [TG_W-1:0] ramp_q;
    logic [TG_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ramp_q <= '0;
            lfsr_q <= LFSR_SEED;
        end else if (adv) begin
            ramp_q <= ramp_q + 1'b1;
            lfsr_q <= lfsr_step(lfsr_q);
        end
    end

    generate
        if (SPARE_LINK) begin : g_spare
            always_comb begin
                unique case (sel)
                    SRC_RAMP: src_word = MARK_SPARE0;
                    SRC_PRNG: src_word = MARK_SPARE1;
                    default:  src_word = MARK_COMMON;
                endcase
            end
        end else begin : g_adc
            always_comb begin
                unique case (sel)
                    SRC_RAMP: src_word = ramp_q;
                    SRC_PRNG: src_word = lfsr_q;
                    default:  src_word = MARK_COMMON;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/lnk_tg_errinj.sv
module lnk_tg_errinj (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic req,
    input  logic consume,
    output logic pend
);

    logic armed_q;
    logic fire;

    assign fire = req && armed_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed_q <= 1'b1;
            pend    <= 1'b0;
        end else begin
            if (fire) begin
                armed_q <= 1'b0;
            end else if (!req) begin
                armed_q <= 1'b1;
            end
            pend <= fire || (pend && !consume);
        end
    end

endmodule

// File: rtl/lnk_testgen.sv
module lnk_testgen
    import lnk_tg_pkg::*;
#(
    parameter bit              SPARE_LINK = 1'b0,
    parameter logic [TG_W-1:0] LFSR_SEED  = 16'hACE1,
    parameter logic [7:0]      ALIGN_CHAR = 8'hBC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            word_tick,
    input  logic [TG_W-1:0] live_data,
    input  logic            test_en,
    input  logic [1:0]      test_sel,
    input  logic            err_req,
    input  logic            ctl_align,
    input  logic            ctl_inhibit,
    input  logic            ctl_link_rst,
    output logic [TG_W-1:0] tx_word,
    output logic [TG_B-1:0] tx_is_k,
    output logic            tx_valid
);

    tg_act_e         act;
    logic            data_go;
    logic            inj_pend;
    logic [TG_W-1:0] src_word;
    logic [TG_W-1:0] base_word;
    tx_beat_t        beat_d;
    tx_beat_t        beat_q;

    always_comb begin
        if (ctl_link_rst)     act = ACT_CLEAR;
        else if (ctl_inhibit) act = ACT_MUTE;
        else if (!word_tick)  act = ACT_HOLD;
        else if (ctl_align)   act = ACT_ALIGN;
        else                  act = ACT_DATA;
    end

    assign data_go = (act == ACT_DATA);

    lnk_tg_source #(
        .SPARE_LINK (SPARE_LINK),
        .LFSR_SEED  (LFSR_SEED)
    ) src_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl_link_rst),
        .adv      (data_go),
        .sel      (src_sel_e'(test_sel)),
        .src_word (src_word)
    );

    lnk_tg_errinj inj_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl_link_rst),
        .req     (err_req),
        .consume (data_go),
        .pend    (inj_pend)
    );

    assign base_word = test_en ? src_word : live_data;

    always_comb begin
        beat_d = beat_q;
        unique case (act)
            ACT_CLEAR, ACT_MUTE: beat_d = '0;
            ACT_ALIGN: begin
                beat_d.data  = {TG_B{ALIGN_CHAR}};
                beat_d.is_k  = '1;
                beat_d.valid = 1'b1;
            end
            ACT_DATA: begin
                beat_d.data  = base_word ^ {{(TG_W-1){1'b0}}, inj_pend};
                beat_d.is_k  = '0;
                beat_d.valid = 1'b1;
            end
            default: beat_d = beat_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign tx_word  = beat_q.data;
    assign tx_is_k  = beat_q.is_k;
    assign tx_valid = beat_q.valid;

endmodule

// File: rtl/lnk_testgen_chk.sv
module lnk_testgen_chk
    import lnk_tg_pkg::*;
#(
    parameter logic [7:0] ALIGN_CHAR = 8'hBC
) (
    input logic            clk,
    input logic            rst,
    input logic            word_tick,
    input logic [TG_W-1:0] live_data,
    input logic            test_en,
    input logic [1:0]      test_sel,
    input logic            ctl_align,
    input logic            ctl_inhibit,
    input logic            ctl_link_rst,
    input logic            inj_pend,
    input logic [TG_W-1:0] tx_word,
    input logic [TG_B-1:0] tx_is_k,
    input logic            tx_valid
);

    logic data_cyc;
    assign data_cyc = word_tick && !ctl_align && !ctl_inhibit && !ctl_link_rst;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!word_tick && !ctl_inhibit && !ctl_link_rst)
        |=> ($stable(tx_word) && $stable(tx_is_k) && $stable(tx_valid)));

    assert_live_R2: assert property (@(posedge clk) disable iff (rst)
        (data_cyc && !test_en)
        |=> (tx_word == ($past(live_data) ^ {{(TG_W-1){1'b0}}, $past(inj_pend)})) && tx_valid);

    assert_marker_R5: assert property (@(posedge clk) disable iff (rst)
        (data_cyc && test_en && test_sel[1] && !inj_pend) |=> (tx_word == 16'hDEAD));

    assert_pend_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (inj_pend && !data_cyc && !ctl_link_rst) |=> inj_pend);

    assert_kflag_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_is_k != '0) |-> ((tx_is_k == '1) && (tx_word == {TG_B{ALIGN_CHAR}}) && tx_valid));

    assert_mute_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_inhibit && !ctl_link_rst) |=> (!tx_valid && tx_word == '0 && tx_is_k == '0));

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        ctl_link_rst |=> (!tx_valid && tx_word == '0 && tx_is_k == '0 && !inj_pend));

endmodule

bind lnk_testgen lnk_testgen_chk #(.ALIGN_CHAR(ALIGN_CHAR)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .word_tick    (word_tick),
    .live_data    (live_data),
    .test_en      (test_en),
    .test_sel     (test_sel),
    .ctl_align    (ctl_align),
    .ctl_inhibit  (ctl_inhibit),
    .ctl_link_rst (ctl_link_rst),
    .inj_pend     (inj_pend),
    .tx_word      (tx_word),
    .tx_is_k      (tx_is_k),
    .tx_valid     (tx_valid)
);

// File: tb/lnk_testgen_tb_top.sv
`timescale 1ns/1ps
module lnk_testgen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_tick = 1'b0;
    logic [15:0] live_data = 16'h0000;
    logic        test_en = 1'b0;
    logic [1:0]  test_sel = 2'b00;
    logic        err_req = 1'b0;
    logic        ctl_align = 1'b0;
    logic        ctl_inhibit = 1'b0;
    logic        ctl_link_rst = 1'b0;
    logic [15:0] tx_word, sp_word;
    logic [1:0]  tx_is_k, sp_is_k;
    logic        tx_valid, sp_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lnk_testgen dut_i (
        .clk(clk), .rst(rst), .word_tick(word_tick), .live_data(live_data),
        .test_en(test_en), .test_sel(test_sel), .err_req(err_req),
        .ctl_align(ctl_align), .ctl_inhibit(ctl_inhibit), .ctl_link_rst(ctl_link_rst),
        .tx_word(tx_word), .tx_is_k(tx_is_k), .tx_valid(tx_valid));

    lnk_testgen #(.SPARE_LINK(1'b1)) dut_spare_i (
        .clk(clk), .rst(rst), .word_tick(word_tick), .live_data(live_data),
        .test_en(test_en), .test_sel(test_sel), .err_req(err_req),
        .ctl_align(ctl_align), .ctl_inhibit(ctl_inhibit), .ctl_link_rst(ctl_link_rst),
        .tx_word(sp_word), .tx_is_k(sp_is_k), .tx_valid(sp_valid));

    // reference model built from the requirements
    logic [15:0] m_ramp, m_lfsr, ew;
    logic [1:0]  ek;
    logic        ev, m_pend, m_armed;

    function automatic logic [15:0] m_step(input logic [15:0] v);
        logic fb;
        fb = v[15] ^ v[13] ^ v[12] ^ v[10];
        return {v[14:0], fb};
    endfunction

    always @(posedge clk) begin
        logic        np;
        logic [15:0] base;
        if (rst || ctl_link_rst) begin
            m_ramp = 16'h0000; m_lfsr = 16'hACE1; m_pend = 1'b0; m_armed = 1'b1;
            ew = 16'h0000; ek = 2'b00; ev = 1'b0;
        end else begin
            np = m_pend;
            if (ctl_inhibit) begin
                ew = 16'h0000; ek = 2'b00; ev = 1'b0;
            end else if (word_tick) begin
                if (ctl_align) begin
                    ew = 16'hBCBC; ek = 2'b11; ev = 1'b1;
                end else begin
                    case (test_sel)
                        2'b00:   base = m_ramp;
                        2'b01:   base = m_lfsr;
                        default: base = 16'hDEAD;
                    endcase
                    if (!test_en) base = live_data;
                    ew = base ^ {15'h0, m_pend}; ek = 2'b00; ev = 1'b1;
                    np = 1'b0;
                    m_ramp = m_ramp + 16'h1;
                    m_lfsr = m_step(m_lfsr);
                end
            end
            if (err_req && m_armed) begin np = 1'b1; m_armed = 1'b0; end
            else if (!err_req) m_armed = 1'b1;
            m_pend = np;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_model(input string req);
        check(req, {15'h0, tx_valid, tx_is_k, tx_word}, {15'h0, ev, ek, ew});
    endtask

    task automatic ticks(input int n);
        @(negedge clk) word_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk) word_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic link_reset();
        @(negedge clk) ctl_link_rst = 1'b1;
        @(negedge clk) ctl_link_rst = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset word", {16'h0, tx_word}, 32'h0);
        check("R1 reset k/valid", {30'h0, tx_is_k}, {31'h0, tx_valid});
        check("R1 reset valid", {31'h0, tx_valid}, 32'h0);
    endtask

    task automatic t_live();
        test_en = 1'b0;
        live_data = 16'h1234; ticks(1); check("R2 live 1234", {16'h0, tx_word}, 32'h1234);
        check("R2 live flags", {29'h0, tx_valid, tx_is_k}, 32'h4);
        live_data = 16'hA5A5; ticks(1); check("R2 live A5A5", {16'h0, tx_word}, 32'hA5A5);
        live_data = 16'h0F0F; idle(3); check("R2 hold without tick", {16'h0, tx_word}, 32'hA5A5);
        ticks(1); check_model("R2 live model");
    endtask

    task automatic t_ramp();
        link_reset();
        test_en = 1'b1; test_sel = 2'b00;
        for (int i = 0; i < 4; i++) begin
            ticks(1); check("R3 ramp step", {16'h0, tx_word}, i);
        end
    endtask

    task automatic t_prng();
        link_reset();
        test_sel = 2'b01;
        ticks(1); check("R4 prng seed", {16'h0, tx_word}, 32'hACE1);
        ticks(1); check("R4 prng second", {16'h0, tx_word}, {16'h0, m_step(16'hACE1)});
        for (int i = 0; i < 5; i++) begin
            ticks(1); check_model("R4 prng sequence");
        end
        test_sel = 2'b00;
        ticks(1); check("R11 ramp advanced during prng", {16'h0, tx_word}, 32'h7);
        test_en = 1'b0; ticks(3); test_en = 1'b1; test_sel = 2'b01;
        ticks(1); check_model("R11 prng advanced during live");
    endtask

    task automatic t_marker();
        test_en = 1'b1;
        test_sel = 2'b10; ticks(1); check("R5 marker sel10", {16'h0, tx_word}, 32'hDEAD);
        test_sel = 2'b11; ticks(1); check("R5 marker sel11", {16'h0, tx_word}, 32'hDEAD);
        check("R6 spare sel11", {16'h0, sp_word}, 32'hDEAD);
        test_sel = 2'b00; ticks(1); check("R6 spare sel00", {16'h0, sp_word}, 32'hF00D);
        test_sel = 2'b01; ticks(1); check("R6 spare sel01", {16'h0, sp_word}, 32'hC01D);
    endtask

    task automatic t_errinj();
        link_reset();
        test_en = 1'b0; live_data = 16'h1234;
        @(negedge clk) err_req = 1'b1;
        idle(1);
        ticks(1); check("R7 one word flipped", {16'h0, tx_word}, 32'h1235);
        ticks(2); check("R7 held request no reflip", {16'h0, tx_word}, 32'h1234);
        @(negedge clk) err_req = 1'b0;
        @(negedge clk) err_req = 1'b1;
        @(negedge clk) err_req = 1'b0;
        ctl_align = 1'b1; ticks(1);
        check("R8 align keeps pending", {16'h0, tx_word}, 32'hBCBC);
        ctl_align = 1'b0; ticks(1); check("R7 rearmed flip", {16'h0, tx_word}, 32'h1235);
        ticks(1); check("R7 only one word", {16'h0, tx_word}, 32'h1234);
    endtask

    task automatic t_align();
        link_reset();
        test_en = 1'b1; test_sel = 2'b00;
        ticks(1); check("R3 ramp after link reset", {16'h0, tx_word}, 32'h0);
        ctl_align = 1'b1; ticks(2);
        check("R8 align word", {16'h0, tx_word}, 32'hBCBC);
        check("R8 align flags", {30'h0, tx_is_k}, 32'h3);
        ctl_align = 1'b0; ticks(1);
        check("R8 data after align", {16'h0, tx_word}, 32'h1);
        check("R8 flags cleared", {30'h0, tx_is_k}, 32'h0);
    endtask

    task automatic t_inhibit();
        @(negedge clk) ctl_inhibit = 1'b1;
        @(negedge clk);
        check("R9 inhibit no tick", {15'h0, tx_valid, tx_word}, 32'h0);
        ticks(2);
        check("R9 inhibit with tick", {13'h0, tx_valid, tx_is_k, tx_word}, 32'h0);
        ctl_inhibit = 1'b0; ticks(1);
        check("R9 no advance under inhibit", {16'h0, tx_word}, 32'h2);
    endtask

    task automatic t_linkrst();
        test_en = 1'b0; live_data = 16'h00F0;
        @(negedge clk) err_req = 1'b1;
        @(negedge clk) err_req = 1'b0;
        link_reset();
        check("R10 outputs cleared", {13'h0, tx_valid, tx_is_k, tx_word}, 32'h0);
        ticks(1); check("R10 pending cleared", {16'h0, tx_word}, 32'h00F0);
    endtask

    task automatic t_wrap();
        link_reset();
        test_en = 1'b1; test_sel = 2'b00;
        ticks(65535);
        check("R3 ramp reaches FFFE", {16'h0, tx_word}, 32'hFFFE);
        ticks(1); check("R3 ramp FFFF", {16'h0, tx_word}, 32'hFFFF);
        ticks(1); check("R3 ramp wraps to 0000", {16'h0, tx_word}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_live();
        t_ramp();
        t_prng();
        t_marker();
        t_errinj();
        t_align();
        t_inhibit();
        t_linkrst();
        t_wrap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule